// File: doc/BRIEF.md
# Two-Level Card-Host Interrupt Aggregator

This block collects one-cycle event pulses from a storage-card host controller and turns them into a single interrupt line. Each pulse latches into a local pending register; software masks those pending bits through a local enable register and acknowledges them by writing ones. The masked result becomes pending bit 0 of a global register that is shared with a sibling controller, whose own pending request enters as a single input and occupies global bit 1.

The global level has two masks. The status-enable mask decides whether a controller's request may latch into the global pending register at all. The signal-enable mask decides which latched global bits drive the output line. All registers sit on a simple strobe-based register port with one-cycle read latency. The usual driver sequence is to acknowledge a source, then enable it. The block ensures that an event which arrived before that acknowledge does not raise the line afterwards.

There is no state machine. The block consists of two register banks and a read multiplexer. The only sequencing is the register chain from an event pulse to the global pending bit and then to the line.

Top module: `cfh_irq_hub`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A pulse on an implemented event bit (bits 0-3 and 8-11 of `ev_pulse`) sets the same bit of the local pending register (offset 0x004) at the next clock edge. Bits 4-7 are never stored and always read 0.
- R3: A write to offset 0x004 clears every pending bit whose write-data bit is one. Bits written as zero keep their value.
- R4: When an event pulse and an acknowledge hit the same local bit in the same cycle, the bit stays set.
- R5: The local enable register (offset 0x008) is read/write and keeps only the implemented bits, so writing all ones reads back 0xF0F.
- R6: Global bit 0 (offset 0x800) sets one edge after any local pending-and-enabled bit is nonzero, provided status-enable bit 0 (offset 0x804) is one. It never sets while that enable bit is zero.
- R7: Global bit 1 follows the `peer_pend` input under status-enable bit 1, with the same latching and clear rules as bit 0.
- R8: Writing a one to a global bit clears it, unless its request is still present in that cycle. In that case it stays set.
- R9: `irq_o` is high exactly when a global pending bit and the matching signal-enable bit (offset 0x808) are both one. It follows those registers without an extra register stage.
- R10: A source event that occurred while the source was disabled does not raise `irq_o` if software acknowledges the source before enabling it.
- R11: Read data appears on `reg_rdata` one clock after the read strobe. Unmapped offsets read 0, and the two global mask registers keep only bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| ev_pulse | input | 12 | One-cycle event pulses from the card controller |
| peer_pend | input | 1 | Pending request level from the sibling controller |
| irq_o | output | 1 | Combined interrupt line |

## Verification
An event pulse appears in the local register one edge later. It reaches the global register on the second edge and is on `irq_o` right after that edge. A register write takes effect at the edge that samples it. A read captures the register values present at its own strobe edge. The bench drives on falling edges and waits the matching number of edges before each check. A scoreboard queue pairs every read with its expected value, and the monitor compares that value one time unit after the capturing edge. The line is checked directly at falling edges, once the two-edge path has settled.

// File: rtl/cfh_irq_pkg.sv
package cfh_irq_pkg;
    localparam int EV_W        = 12;
    localparam logic [EV_W-1:0] EV_IMPL = 12'hF0F;
    localparam int N_CTRL      = 2;
    localparam int OFF_LSTS    = 'h004;
    localparam int OFF_LEN     = 'h008;
    localparam int OFF_GSTS    = 'h800;
    localparam int OFF_GSEN    = 'h804;
    localparam int OFF_GSIG    = 'h808;
endpackage

// File: rtl/cfh_irq_local.sv
module cfh_irq_local #(
    parameter int EV_W = 12,
    parameter logic [EV_W-1:0] IMPL = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_pulse,
    input  logic            ack_wr,
    input  logic            en_wr,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] sts_q,
    output logic [EV_W-1:0] en_q,
    output logic            pend
);
    for (genvar i = 0; i < EV_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sts_q[i] <= 1'b0;
                    en_q[i]  <= 1'b0;
                end else begin
                    sts_q[i] <= ev_pulse[i] | (sts_q[i] & ~(ack_wr & wdata[i]));
                    if (en_wr) en_q[i] <= wdata[i];
                end
            end

            // R4
            ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ev_pulse[i] |=> sts_q[i]);
            // R3
            ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_wr && wdata[i] && !ev_pulse[i]) |=> !sts_q[i]);
        end else begin : g_tied
            assign sts_q[i] = 1'b0;
            assign en_q[i]  = 1'b0;
        end
    end

    assign pend = |(sts_q & en_q);
endmodule

// File: rtl/cfh_irq_global.sv
module cfh_irq_global #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pend,
    input  logic             ack_wr,
    input  logic             sen_wr,
    input  logic             sig_wr,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] gsts_q,
    output logic [N_SRC-1:0] gsen_q,
    output logic [N_SRC-1:0] gsig_q,
    output logic             irq_o
);
    logic [N_SRC-1:0] req;
    assign req = src_pend & gsen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gsts_q <= '0;
            gsen_q <= '0;
            gsig_q <= '0;
        end else begin
            gsts_q <= req | (gsts_q & ~({N_SRC{ack_wr}} & wdata));
            if (sen_wr) gsen_q <= wdata;
            if (sig_wr) gsig_q <= wdata;
        end
    end

    assign irq_o = |(gsts_q & gsig_q);

    for (genvar k = 0; k < N_SRC; k++) begin : g_chk
        // R6
        gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gsts_q[k]) |-> $past(gsen_q[k] && src_pend[k]));
        // R8
        gack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr && wdata[k] && !(src_pend[k] && gsen_q[k])) |=> !gsts_q[k]);
    end

    // R9
    line_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gsig_q != '0));
endmodule

// File: rtl/cfh_irq_hub.sv
module cfh_irq_hub
    import cfh_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EV_W-1:0]   ev_pulse,
    input  logic              peer_pend,
    output logic              irq_o
);
    localparam int CTRL_BIT = 0;
    localparam int PEER_BIT = 1;

    logic sel_lsts, sel_len, sel_gsts, sel_gsen, sel_gsig;
    assign sel_lsts = (reg_addr == ADDR_W'(OFF_LSTS));
    assign sel_len  = (reg_addr == ADDR_W'(OFF_LEN));
    assign sel_gsts = (reg_addr == ADDR_W'(OFF_GSTS));
    assign sel_gsen = (reg_addr == ADDR_W'(OFF_GSEN));
    assign sel_gsig = (reg_addr == ADDR_W'(OFF_GSIG));

    logic [EV_W-1:0]   lsts, len;
    logic              loc_pend;
    logic [N_CTRL-1:0] gsts, gsen, gsig, src;

    cfh_irq_local #(.EV_W(EV_W), .IMPL(EV_IMPL)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_pulse (ev_pulse),
        .ack_wr   (reg_wr & sel_lsts),
        .en_wr    (reg_wr & sel_len),
        .wdata    (reg_wdata[EV_W-1:0]),
        .sts_q    (lsts),
        .en_q     (len),
        .pend     (loc_pend)
    );

    always_comb begin
        src = '0;
        src[CTRL_BIT] = loc_pend;
        src[PEER_BIT] = peer_pend;
    end

    cfh_irq_global #(.N_SRC(N_CTRL)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pend (src),
        .ack_wr   (reg_wr & sel_gsts),
        .sen_wr   (reg_wr & sel_gsen),
        .sig_wr   (reg_wr & sel_gsig),
        .wdata    (reg_wdata[N_CTRL-1:0]),
        .gsts_q   (gsts),
        .gsen_q   (gsen),
        .gsig_q   (gsig),
        .irq_o    (irq_o)
    );

    logic unused_hi;
    assign unused_hi = ^reg_wdata[DATA_W-1:EV_W];

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (sel_lsts) rd_mux = DATA_W'(lsts);
        if (sel_len)  rd_mux = DATA_W'(len);
        if (sel_gsts) rd_mux = DATA_W'(gsts);
        if (sel_gsen) rd_mux = DATA_W'(gsen);
        if (sel_gsig) rd_mux = DATA_W'(gsig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_cfh_irq_hub.sv
module sim_cfh_irq_hub;
    localparam time TCK = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [11:0] ev_pulse = 0;
    logic        peer_pend = 0;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #(TCK/2) clk = ~clk;

    cfh_irq_hub u0 (.*);

    // monitor: compare each read one time unit after the capturing edge
    always @(posedge clk) begin
        if (reg_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            #1;
            n_run++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pulse(input logic [11:0] v);
        @(negedge clk);
        ev_pulse = v;
        @(negedge clk);
        ev_pulse = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_run++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s: irq_o actual %b expected %b", t, irq_o, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk_irq(0, "R1");
        rd(12'h004, 0, "R1 lsts"); rd(12'h008, 0, "R1 len");
        rd(12'h800, 0, "R1 gsts"); rd(12'h804, 0, "R1 gsen");
        rd(12'h808, 0, "R1 gsig");
        // R2 implemented bits only
        pulse(12'hFFF);
        rd(12'h004, 32'hF0F, "R2");
        // R3 write-one-to-clear, zeros keep
        wr(12'h004, 32'h00F); rd(12'h004, 32'hF00, "R3 ones");
        wr(12'h004, 32'h000); rd(12'h004, 32'hF00, "R3 zeros");
        // R4 event and clear in same cycle
        @(negedge clk);
        reg_wr = 1; reg_addr = 12'h004; reg_wdata = 32'h100; ev_pulse = 12'h100;
        @(negedge clk);
        reg_wr = 0; ev_pulse = 0;
        rd(12'h004, 32'hF00, "R4");
        // R5 enable readback
        wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, 32'hF0F, "R5");
        // R6 gate closed
        idle(2); rd(12'h800, 0, "R6 gated");
        wr(12'h804, 32'h1); idle(1); rd(12'h800, 32'h1, "R6 open");
        // R9 masking by signal enable
        chk_irq(0, "R9 sig off");
        wr(12'h808, 32'h1); chk_irq(1, "R9 sig on");
        // R8 clear while request present stays
        wr(12'h800, 32'h1); rd(12'h800, 32'h1, "R8 held");
        wr(12'h004, 32'hFFF); idle(1);
        wr(12'h800, 32'h1); rd(12'h800, 0, "R8 cleared");
        chk_irq(0, "R8 line low");
        // R7 peer bit
        peer_pend = 1; idle(2); rd(12'h800, 0, "R7 gated");
        wr(12'h804, 32'h3); idle(1); rd(12'h800, 32'h2, "R7 set");
        chk_irq(0, "R9 peer masked");
        wr(12'h808, 32'h2); chk_irq(1, "R9 peer line");
        peer_pend = 0; idle(1);
        wr(12'h800, 32'h2); rd(12'h800, 0, "R7 cleared");
        chk_irq(0, "R7 line low");
        // R10 clear-then-enable
        wr(12'h008, 0); wr(12'h808, 32'h3);
        pulse(12'h800); idle(2); chk_irq(0, "R10 disabled");
        wr(12'h004, 32'h800); wr(12'h008, 32'h800);
        idle(3); chk_irq(0, "R10 stale");
        rd(12'h800, 0, "R10 gsts");
        pulse(12'h800); idle(1); chk_irq(1, "R10 live event");
        // R11 unmapped and mask width
        rd(12'h010, 0, "R11 unmapped");
        wr(12'h804, 32'hFFFF_FFFF); rd(12'h804, 32'h3, "R11 gsen width");
        idle(2);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule